// File: doc/BRIEF.md
# Dual-Ratio Fractional Clock Divider

This block derives a slower clock from a fast reference clock, such as a crystal oscillator, when no single whole-number ratio gives the wanted rate. It has two integer ratios. In dual mode it stays on the first ratio for a set number of output periods, then on the second ratio for its own set number, and repeats. Over one full round the output therefore averages a rate between the two integer rates. In single mode only the first ratio is used. A bypass path sends the gated reference straight to the output.

All configuration fields are static inputs, and each one holds its value minus one. The block also drives a pulse at the start of every output period, a flag that marks each change of ratio, and a level that shows which ratio is in use. All logic runs on the reference clock. The reset is synchronous and active high.

Top module: `fdiv_dual_ratio`

## Requirements
- R1: In single mode every output period lasts exactly n1_i+1 reference cycles. Each ratio field and dwell field holds its value minus one.
- R2: In a period of n reference cycles (n ≥ 2), the output is high for the first floor(n/2) cycles and low for the rest. When n = 1 the output follows the reference clock.
- R3: In dual mode the block produces m1_i+1 periods of n1_i+1 cycles, then m2_i+1 periods of n2_i+1 cycles, and repeats. One full round therefore holds (m1_i+1)+(m2_i+1) output rising edges within (m1_i+1)(n1_i+1)+(m2_i+1)(n2_i+1) reference cycles.
- R4: When dual_i is 0, the values of n2_i, m1_i and m2_i have no effect, and sel_o stays 0 at every period start.
- R5: When bypass_i is 1, div_clk_o equals clk_i AND en_i, and tick_o stays 0.
- R6: When en_i falls, the period in progress runs to its end. After that, div_clk_o and tick_o stay 0.
- R7: A change to a ratio or dwell field takes effect only at the next period boundary. The period in progress keeps its length.
- R8: tick_o is high for the first reference cycle of every output period and at no other time.
- R9: swap_o is high together with tick_o when the new period uses a different ratio from the previous one. sel_o is 1 while the second ratio is in use and 0 while the first is.
- R10: While rst_i is high, div_clk_o, tick_o, swap_o and sel_o are 0. After reset, and after each re-enable, the pattern restarts on the first ratio with swap_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Enable for the input and output gates |
| bypass_i | input | 1 | Sends the gated reference straight to the output |
| dual_i | input | 1 | 1 alternates between the two ratios, 0 uses only the first |
| n1_i | input | FIELD_W | First ratio minus one |
| n2_i | input | FIELD_W | Second ratio minus one |
| m1_i | input | DWELL_W | Periods on the first ratio, minus one |
| m2_i | input | DWELL_W | Periods on the second ratio, minus one |
| div_clk_o | output | 1 | Divided clock |
| tick_o | output | 1 | One-cycle pulse at the start of each output period |
| swap_o | output | 1 | Goes high with tick_o when the ratio changes |
| sel_o | output | 1 | 1 while the second ratio is in use |

## Verification
The bench runs several ratio and dwell sets through one table. Each set is checked by counting reference cycles and output rising edges over a full round. The sets include a unit first ratio, a dwell of one period, a long second dwell, and single mode with junk values in the unused fields. Together these separate a correct alternation from one that gets a dwell count wrong by one, mixes up the ratios, or reads the unused fields. Directed tests then check:
- the duty split within a period;
- a ratio change in the middle of a period;
- enable removal partway through a period;
- bypass sampled on both phases of the reference;
- the ordering of the ratio-change flag and a reset taken while the second ratio is in use.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    localparam int FIELD_W = 8;
    localparam int DWELL_W = 8;
    localparam int LEN_W   = FIELD_W + 1;

    typedef logic [FIELD_W-1:0] field_t;
    typedef logic [DWELL_W-1:0] dwell_t;
    typedef logic [LEN_W-1:0]   len_t;

    typedef enum logic {
        SEL_FIRST  = 1'b0,
        SEL_SECOND = 1'b1
    } ratio_sel_e;

    // State of the period counter
    typedef struct packed {
        logic run;
        logic hi;
        logic tick;
        len_t len;
        len_t pos;
    } period_st_t;

    // A stored field is the ratio minus one
    function automatic len_t field_to_len(field_t f);
        return len_t'(f) + len_t'(1);
    endfunction

    // Number of high cycles in a period of length l
    function automatic len_t high_span(len_t l);
        return l >> 1;
    endfunction

endpackage

// File: rtl/fdiv_period_ctr.sv
module fdiv_period_ctr
    import fdiv_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       go_i,
    input  len_t       len_load_i,
    output logic       at_end_o,
    output period_st_t st_o
);

    period_st_t st_q;

    // A boundary is the last cycle of a period, or any cycle while idle
    assign at_end_o = !st_q.run || (st_q.pos == st_q.len - len_t'(1));

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else if (at_end_o) begin
            if (go_i) begin
                st_q.run  <= 1'b1;
                st_q.len  <= len_load_i;
                st_q.pos  <= '0;
                st_q.hi   <= (len_load_i > len_t'(1));
                st_q.tick <= 1'b1;
            end else begin
                st_q <= '0;
            end
        end else begin
            st_q.pos  <= st_q.pos + len_t'(1);
            st_q.hi   <= ((st_q.pos + len_t'(1)) < high_span(st_q.len));
            st_q.tick <= 1'b0;
        end
    end

    assign st_o = st_q;

endmodule

// File: rtl/fdiv_dwell_seq.sv
module fdiv_dwell_seq
    import fdiv_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       step_i,
    input  logic       fresh_i,
    input  logic       dual_i,
    input  dwell_t     m1_i,
    input  dwell_t     m2_i,
    output ratio_sel_e sel_next_o,
    output ratio_sel_e sel_o,
    output logic       swap_o
);

    ratio_sel_e sel_q;
    dwell_t     dw_q;
    dwell_t     dw_next;
    dwell_t     lim;
    logic       swap_q;

    always_comb begin
        lim = (sel_q == SEL_SECOND) ? m2_i : m1_i;
        if (fresh_i || !dual_i) begin
            sel_next_o = SEL_FIRST;
            dw_next    = '0;
        end else if (dw_q == lim) begin
            sel_next_o = (sel_q == SEL_FIRST) ? SEL_SECOND : SEL_FIRST;
            dw_next    = '0;
        end else begin
            sel_next_o = sel_q;
            dw_next    = dw_q + dwell_t'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sel_q  <= SEL_FIRST;
            dw_q   <= '0;
            swap_q <= 1'b0;
        end else if (step_i) begin
            sel_q  <= sel_next_o;
            dw_q   <= dw_next;
            swap_q <= !fresh_i && (sel_next_o != sel_q);
        end else begin
            swap_q <= 1'b0;
        end
    end

    assign sel_o  = sel_q;
    assign swap_o = swap_q;

endmodule

// File: rtl/fdiv_out_gate.sv
module fdiv_out_gate (
    input  logic clk_i,
    input  logic en_i,
    input  logic bypass_i,
    input  logic run_i,
    input  logic unity_i,
    input  logic hi_i,
    output logic clk_o
);

    logic div_path;

    // A ratio of one passes the reference; otherwise the registered phase
    assign div_path = run_i & (unity_i ? clk_i : hi_i);
    assign clk_o    = bypass_i ? (clk_i & en_i) : div_path;

endmodule

// File: rtl/fdiv_dual_ratio.sv
module fdiv_dual_ratio
    import fdiv_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               en_i,
    input  logic               bypass_i,
    input  logic               dual_i,
    input  logic [FIELD_W-1:0] n1_i,
    input  logic [FIELD_W-1:0] n2_i,
    input  logic [DWELL_W-1:0] m1_i,
    input  logic [DWELL_W-1:0] m2_i,
    output logic               div_clk_o,
    output logic               tick_o,
    output logic               swap_o,
    output logic               sel_o
);

    period_st_t st_w;
    ratio_sel_e sel_next_w;
    ratio_sel_e sel_w;
    len_t       len_load_w;
    logic       at_end_w;
    logic       go_w;
    logic       step_w;
    logic       run_w;
    logic       hi_w;
    len_t       len_w;
    len_t       pos_w;

    assign go_w       = en_i && !bypass_i;
    assign step_w     = at_end_w && go_w;
    assign len_load_w = field_to_len((sel_next_w == SEL_SECOND) ? n2_i : n1_i);

    fdiv_period_ctr u_period (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .go_i       (go_w),
        .len_load_i (len_load_w),
        .at_end_o   (at_end_w),
        .st_o       (st_w)
    );

    assign run_w = st_w.run;
    assign hi_w  = st_w.hi;
    assign len_w = st_w.len;
    assign pos_w = st_w.pos;

    fdiv_dwell_seq u_dwell (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .step_i     (step_w),
        .fresh_i    (!run_w),
        .dual_i     (dual_i),
        .m1_i       (m1_i),
        .m2_i       (m2_i),
        .sel_next_o (sel_next_w),
        .sel_o      (sel_w),
        .swap_o     (swap_o)
    );

    fdiv_out_gate u_gate (
        .clk_i    (clk_i),
        .en_i     (en_i),
        .bypass_i (bypass_i),
        .run_i    (run_w),
        .unity_i  (len_w == len_t'(1)),
        .hi_i     (hi_w),
        .clk_o    (div_clk_o)
    );

    assign tick_o = st_w.tick;
    assign sel_o  = (sel_w == SEL_SECOND);

endmodule

// File: rtl/fdiv_dual_ratio_chk.sv
module fdiv_dual_ratio_chk
    import fdiv_pkg::*;
(
    input logic clk_i,
    input logic rst_i,
    input logic dual_i,
    input logic tick_o,
    input logic swap_o,
    input logic sel_o,
    input logic run_i,
    input logic hi_i,
    input len_t len_i,
    input len_t pos_i
);

    // R8
    tick_in_run_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_o |-> run_i);

    // R9
    swap_on_tick_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        swap_o |-> tick_o);

    // R7
    len_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_i && !tick_o) |-> $stable(len_i));

    // R1
    pos_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        run_i |-> (pos_i < len_i));

    // R6
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !run_i |-> (!hi_i && !tick_o));

    // R4
    single_sel_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (tick_o && !$past(dual_i)) |-> !sel_o);

    // R10
    reset_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (!tick_o && !run_i && !swap_o));

endmodule

bind fdiv_dual_ratio fdiv_dual_ratio_chk u_chk (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .dual_i (dual_i),
    .tick_o (tick_o),
    .swap_o (swap_o),
    .sel_o  (sel_o),
    .run_i  (run_w),
    .hi_i   (hi_w),
    .len_i  (len_w),
    .pos_i  (pos_w)
);

// File: tb/fdiv_dual_ratio_test.sv
module fdiv_dual_ratio_test;
    import fdiv_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    localparam int NVEC       = 6;

    typedef struct packed {
        logic   dual;
        field_t n1;
        field_t n2;
        dwell_t m1;
        dwell_t m2;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 8'd2, 8'd3, 8'd1, 8'd0},
        '{1'b1, 8'd0, 8'd1, 8'd2, 8'd2},
        '{1'b1, 8'd4, 8'd5, 8'd3, 8'd1},
        '{1'b0, 8'd6, 8'd1, 8'd0, 8'd0},
        '{1'b1, 8'd7, 8'd2, 8'd0, 8'd4},
        '{1'b0, 8'd1, 8'd9, 8'd7, 8'd3}
    };

    logic   clk = 1'b0;
    logic   rst_i, en_i, bypass_i, dual_i;
    field_t n1_i, n2_i;
    dwell_t m1_i, m2_i;
    logic   div_clk_o, tick_o, swap_o, sel_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int edge_cnt = 0;
    logic meas = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fdiv_dual_ratio uut (
        .clk_i     (clk),
        .rst_i     (rst_i),
        .en_i      (en_i),
        .bypass_i  (bypass_i),
        .dual_i    (dual_i),
        .n1_i      (n1_i),
        .n2_i      (n2_i),
        .m1_i      (m1_i),
        .m2_i      (m2_i),
        .div_clk_o (div_clk_o),
        .tick_o    (tick_o),
        .swap_o    (swap_o),
        .sel_o     (sel_o)
    );

    always @(posedge div_clk_o) if (meas) edge_cnt++;

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
            summary();
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic restart(logic d, field_t a, field_t b, dwell_t c, dwell_t e);
        @(negedge clk);
        rst_i = 1'b1; dual_i = d; n1_i = a; n2_i = b; m1_i = c; m2_i = e;
        en_i = 1'b1; bypass_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_i = 1'b0;
    endtask

    task automatic wait_tick();
        do @(negedge clk); while (!tick_o);
    endtask

    task automatic wait_round();
        do @(negedge clk); while (!(tick_o && swap_o && !sel_o));
    endtask

    initial begin
        rst_i = 1'b1; en_i = 1'b1; bypass_i = 1'b0; dual_i = 1'b1;
        n1_i = 8'd3; n2_i = 8'd4; m1_i = 8'd1; m2_i = 8'd1;

        // R10: outputs quiet during reset
        @(negedge clk); @(negedge clk);
        check("R10 div in reset", int'(div_clk_o), 0);
        check("R10 tick in reset", int'(tick_o), 0);
        check("R10 swap in reset", int'(swap_o), 0);
        check("R10 sel in reset", int'(sel_o), 0);

        // R3 / R1 / R4: rate over a round or over four periods
        for (int v = 0; v < NVEC; v++) begin
            int cyc;
            int bad_sel;
            int exp_cyc;
            int exp_edges;
            restart(VECS[v].dual, VECS[v].n1, VECS[v].n2, VECS[v].m1, VECS[v].m2);
            cyc = 0;
            bad_sel = 0;
            if (VECS[v].dual) begin
                exp_cyc = (int'(VECS[v].m1) + 1) * (int'(VECS[v].n1) + 1)
                        + (int'(VECS[v].m2) + 1) * (int'(VECS[v].n2) + 1);
                exp_edges = int'(VECS[v].m1) + int'(VECS[v].m2) + 2;
                wait_round();
                edge_cnt = 0; meas = 1'b1;
                do begin @(negedge clk); cyc++; end while (!(tick_o && swap_o && !sel_o));
                meas = 1'b0;
                check($sformatf("R3 round cycles vec %0d", v), cyc, exp_cyc);
                check($sformatf("R3 round edges vec %0d", v), edge_cnt, exp_edges);
            end else begin
                int seen;
                exp_cyc = 4 * (int'(VECS[v].n1) + 1);
                exp_edges = 4;
                seen = 0;
                wait_tick();
                edge_cnt = 0; meas = 1'b1;
                while (seen < 4) begin
                    @(negedge clk); cyc++;
                    if (tick_o) begin
                        seen++;
                        if (sel_o) bad_sel++;
                    end
                end
                meas = 1'b0;
                check($sformatf("R1 single cycles vec %0d", v), cyc, exp_cyc);
                check($sformatf("R1 single edges vec %0d", v), edge_cnt, exp_edges);
                check($sformatf("R4 sel stays first vec %0d", v), bad_sel, 0);
            end
        end

        // R2: duty split, period of 5
        restart(1'b0, 8'd4, 8'd0, 8'd0, 8'd0);
        wait_tick();
        for (int p = 0; p < 5; p++) begin
            check($sformatf("R2 level pos %0d", p), int'(div_clk_o), (p < 2) ? 1 : 0);
            check($sformatf("R8 tick pos %0d", p), int'(tick_o), (p == 0) ? 1 : 0);
            @(negedge clk);
        end
        check("R8 tick at next period", int'(tick_o), 1);

        // R2: ratio of one follows the reference
        restart(1'b0, 8'd0, 8'd0, 8'd0, 8'd0);
        wait_tick();
        @(posedge clk); #1;
        check("R2 unity high phase", int'(div_clk_o), 1);
        @(negedge clk); #1;
        check("R2 unity low phase", int'(div_clk_o), 0);
        check("R8 unity tick each cycle", int'(tick_o), 1);

        // R7: mid-period change applies at the boundary
        restart(1'b0, 8'd5, 8'd0, 8'd0, 8'd0);
        wait_tick();
        @(negedge clk);
        n1_i = 8'd2;
        begin
            int c = 0;
            do begin @(negedge clk); c++; end while (!tick_o);
            check("R7 current period kept", c, 5);
            c = 0;
            do begin @(negedge clk); c++; end while (!tick_o);
            check("R7 new ratio next period", c, 3);
        end

        // R6: enable removed at the start of a 6-cycle period
        restart(1'b0, 8'd5, 8'd0, 8'd0, 8'd0);
        wait_tick();
        en_i = 1'b0;
        @(negedge clk);
        check("R6 period continues pos1", int'(div_clk_o), 1);
        @(negedge clk);
        check("R6 period continues pos2", int'(div_clk_o), 1);
        @(negedge clk); @(negedge clk); @(negedge clk);
        begin
            int act = 0;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (div_clk_o || tick_o) act++;
                @(posedge clk); #1;
                if (div_clk_o) act++;
            end
            check("R6 quiet after period", act, 0);
        end

        // R5: bypass follows the gated reference
        restart(1'b0, 8'd5, 8'd0, 8'd0, 8'd0);
        bypass_i = 1'b1;
        @(posedge clk); #1;
        check("R5 bypass high phase", int'(div_clk_o), 1);
        @(negedge clk); #1;
        check("R5 bypass low phase", int'(div_clk_o), 0);
        @(posedge clk); #1;
        check("R5 no tick in bypass", int'(tick_o), 0);
        en_i = 1'b0;
        @(posedge clk); #1;
        check("R5 bypass gated by enable", int'(div_clk_o), 0);
        bypass_i = 1'b0; en_i = 1'b1;

        // R9 / R10: order of ratio flags, reset during second ratio
        restart(1'b1, 8'd1, 8'd2, 8'd1, 8'd0);
        wait_tick();
        check("R10 first tick sel", int'(sel_o), 0);
        check("R10 first tick swap", int'(swap_o), 0);
        wait_tick();
        check("R9 second tick sel", int'(sel_o), 0);
        check("R9 second tick swap", int'(swap_o), 0);
        wait_tick();
        check("R9 third tick sel", int'(sel_o), 1);
        check("R9 third tick swap", int'(swap_o), 1);
        wait_tick();
        check("R9 fourth tick sel", int'(sel_o), 0);
        check("R9 fourth tick swap", int'(swap_o), 1);
        do wait_tick(); while (!sel_o);
        rst_i = 1'b1;
        @(negedge clk); @(negedge clk);
        rst_i = 1'b0;
        wait_tick();
        check("R10 restart sel", int'(sel_o), 0);
        check("R10 restart swap", int'(swap_o), 0);

        summary();
    end

endmodule